// File: doc/BRIEF.md
# Multi-Rail Supervisor Output Sequencer

This block is the digital controller that sits behind the comparators of a four-rail voltage supervisor. For each rail it receives two synchronous comparator flags: one says the high tap is below threshold and one says the low tap is above threshold. A glitch filter cleans each flag. The block then sorts the filtered flags into undervoltage and overvoltage faults, using a polarity select that can make rails 3 and 4 negative. It drives two active-low outputs, one for undervoltage and one for overvoltage.

After its faults clear, each output is held asserted for a programmable number of cycles, and each output has its own counter. A bypass input removes this hold. A supply-lockout input forces undervoltage asserted and overvoltage inactive. After lockout ends, undervoltage goes through a full release hold. A build-time parameter selects one of two variants, and the shared control input `ovl_ctrl` has a different meaning in each:
- In the latching variant, an overvoltage event seen while `ovl_ctrl` is low stays latched until `ovl_ctrl` is driven high.
- In the disable variant, a high `ovl_ctrl` forces both outputs inactive. Lockout still asserts undervoltage, without any hold.

Top module: `rail_fault_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is sampled, `uv_n` is 0, `ov_n` is 1, every filter is cleared and any overvoltage latch is cleared.
- R2: Rails 1 and 2 are always positive. `hi_below[i]` (rail i+1) is an undervoltage fault and `lo_above[i]` is an overvoltage fault.
- R3: `pol_sel` encoding:
  - 2'b10 or 2'b11 makes rails 3 and 4 positive.
  - 2'b01 makes rail 3 positive and rail 4 negative.
  - 2'b00 makes both negative.
  - On a negative rail, `hi_below` is an overvoltage fault and `lo_above` is an undervoltage fault.
- R4: The output timing is:
  - `uv_n` goes low one cycle after any filtered undervoltage fault.
  - `ov_n` goes low one cycle after any filtered overvoltage fault.
  - Faults on different rails combine.
- R5: Let L = `tmo_load`, with 0 treated as 1. If the last clock edge that sees a filtered fault is edge k, the output returns high right after edge k+L. With a filter length N, an output counted from the cycle its raw flag drops releases on the (N+L)-th falling clock edge.
- R6: A new fault during the release hold restarts it, so the full L cycles are counted from the last faulty edge.
- R7: With `tmo_bypass` high, L is 1 whatever `tmo_load` holds.
- R8: A flag change is accepted only after it has been seen on N = `filt_len` consecutive clock edges (0 is treated as 1). A shorter pulse has no effect on the outputs.
- R9: While `lockout` is high:
  - `uv_n` is 0 and `ov_n` is 1.
  - Any overvoltage latch is cleared.
  - After lockout ends, `uv_n` is released at the L-th falling edge, as if an undervoltage fault had just cleared.
- R10: Latching variant (`LATCH_VARIANT`=1): an overvoltage fault seen while `ovl_ctrl`=0 keeps `ov_n` low, beyond the hold, until `ovl_ctrl`=1. That edge releases `ov_n` at once if no fault remains. While `ovl_ctrl`=1, `ov_n` uses the R5 hold.
- R11: Latching variant: if `ovl_ctrl` falls while `ov_n` is in its release hold, `ov_n` latches low.
- R12: Disable variant (`LATCH_VARIANT`=0): while `ovl_ctrl`=1 and `lockout`=0, both outputs are high one cycle later, whatever the flags.
- R13: Disable variant: with `ovl_ctrl`=1, lockout asserts `uv_n`, and `uv_n` returns high on the first edge after lockout ends, with no hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_below | input | 4 | Per-rail high-tap-below-threshold flags, bit i = rail i+1 |
| lo_above | input | 4 | Per-rail low-tap-above-threshold flags, bit i = rail i+1 |
| pol_sel | input | 2 | Polarity select for rails 3 and 4 (see R3) |
| lockout | input | 1 | Supply lockout flag |
| tmo_bypass | input | 1 | Removes the release hold |
| tmo_load | input | TW | Release hold length in cycles |
| filt_len | input | FW | Glitch filter length in cycles |
| ovl_ctrl | input | 1 | Latch-clear (latching variant) or disable (disable variant) |
| uv_n | output | 1 | Active-low undervoltage output |
| ov_n | output | 1 | Active-low overvoltage output |

## Verification
The assertions take for granted that the comparator flags, lockout and control inputs are synchronous to `clk` and settled at each rising edge. The bench meets this by changing them only just after a falling edge. The bench's cycle model also assumes that the hold length is never raised while an output has already been released. So the stimulus changes `tmo_load` and `tmo_bypass` only while a fault is present, or after a quiet stretch longer than any hold value in use. Within those limits the bench drives:
- an exhaustive sweep of all flag patterns under every polarity code;
- directed release-timing, latch, lockout and disable sequences;
- long pseudo-random runs that compare both variants against a cycle model every cycle.

// File: rtl/rail_fault_sequencer.sv
module rail_fault_sequencer #(
  parameter int TW = 16,
  parameter int FW = 4,
  parameter int LATCH_VARIANT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    hi_below,
  input  logic [3:0]    lo_above,
  input  logic [1:0]    pol_sel,
  input  logic          lockout,
  input  logic          tmo_bypass,
  input  logic [TW-1:0] tmo_load,
  input  logic [FW-1:0] filt_len,
  input  logic          ovl_ctrl,
  output logic          uv_n,
  output logic          ov_n
);

  localparam int  NF = 8;
  localparam bit  LV = (LATCH_VARIANT != 0);

  logic [NF-1:0] raw_w;
  logic [NF-1:0] flt;
  logic [FW-1:0] need;

  assign raw_w = {lo_above, hi_below};
  assign need  = (filt_len == '0) ? FW'(1) : filt_len;

  for (genvar i = 0; i < NF; i++) begin : g_flt
    logic          f;
    logic [FW-1:0] run;
    logic [FW:0]   run_nx;
    assign run_nx = {1'b0, run} + 1'b1;
    always_ff @(posedge clk) begin
      if (rst) begin
        f   <= 1'b0;
        run <= '0;
      end else if (raw_w[i] == f) begin
        run <= '0;
      end else if (run_nx >= {1'b0, need}) begin
        f   <= raw_w[i];
        run <= '0;
      end else begin
        run <= run_nx[FW-1:0];
      end
    end
    assign flt[i] = f;
  end

  logic [3:0] neg, hi_f, lo_f;
  logic       uv_fault, ov_fault;

  assign neg      = {~pol_sel[1], (pol_sel == 2'b00), 2'b00};
  assign hi_f     = flt[3:0];
  assign lo_f     = flt[7:4];
  assign uv_fault = |((hi_f & ~neg) | (lo_f & neg));
  assign ov_fault = |((lo_f & ~neg) | (hi_f & neg));

  logic dis, lat_lo, lat_hi;
  assign dis    = !LV && ovl_ctrl;
  assign lat_lo = LV && !ovl_ctrl;
  assign lat_hi = LV && ovl_ctrl;

  logic          uv_act, ov_act, ov_lat;
  logic [TW-1:0] uv_cnt, ov_cnt;
  logic [TW:0]   uv_nx, ov_nx;
  logic          uv_done, ov_done;

  assign uv_nx   = {1'b0, uv_cnt} + 1'b1;
  assign ov_nx   = {1'b0, ov_cnt} + 1'b1;
  assign uv_done = tmo_bypass || (uv_nx >= {1'b0, tmo_load});
  assign ov_done = tmo_bypass || (ov_nx >= {1'b0, tmo_load});

  always_ff @(posedge clk) begin
    if (rst || lockout) begin
      uv_act <= 1'b1;
      uv_cnt <= '0;
    end else if (dis) begin
      uv_act <= 1'b0;
      uv_cnt <= '0;
    end else if (uv_fault) begin
      uv_act <= 1'b1;
      uv_cnt <= '0;
    end else if (uv_act) begin
      if (uv_done) uv_act <= 1'b0;
      else         uv_cnt <= uv_nx[TW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || lockout) begin
      ov_act <= 1'b0;
      ov_lat <= 1'b0;
      ov_cnt <= '0;
    end else if (dis) begin
      ov_act <= 1'b0;
      ov_cnt <= '0;
    end else if (ov_lat && lat_hi) begin
      ov_lat <= 1'b0;
      ov_act <= ov_fault;
      ov_cnt <= '0;
    end else if (ov_fault) begin
      ov_act <= 1'b1;
      ov_cnt <= '0;
      ov_lat <= lat_lo;
    end else if (ov_act && lat_lo) begin
      ov_lat <= 1'b1;
    end else if (ov_act) begin
      if (ov_done) ov_act <= 1'b0;
      else         ov_cnt <= ov_nx[TW-1:0];
    end
  end

  assign uv_n = ~uv_act;
  assign ov_n = ~ov_act;

  a_r8_filter_accept: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((flt ^ $past(flt)) & (flt ^ $past(raw_w))) == '0));

  a_r9_lockout_uv: assert property (@(posedge clk) disable iff (rst)
    lockout |=> !uv_n);

  a_r9_lockout_ov: assert property (@(posedge clk) disable iff (rst)
    lockout |=> ov_n);

  a_r4_uv_assert: assert property (@(posedge clk) disable iff (rst)
    (uv_fault && !dis) |=> !uv_n);

  a_r7_bypass_release: assert property (@(posedge clk) disable iff (rst)
    (tmo_bypass && !uv_fault && !lockout) |=> uv_n);

  if (LV) begin : g_lat_chk
    a_r10_latch_hold: assert property (@(posedge clk) disable iff (rst)
      (!ov_n && !ovl_ctrl && !lockout) |=> !ov_n);
  end else begin : g_dis_chk
    a_r12_disable_force: assert property (@(posedge clk) disable iff (rst)
      (ovl_ctrl && !lockout) |=> (uv_n && ov_n));
  end

endmodule

// File: tb/sim_rail_fault_sequencer.sv
module sim_rail_fault_sequencer;
  localparam int TW  = 8;
  localparam int FW  = 3;
  localparam int BIG = 1 << 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, lockout, tmo_bypass, lat_in, dis_in;
  logic [3:0]    hi_below, lo_above;
  logic [1:0]    pol_sel;
  logic [TW-1:0] tmo_load;
  logic [FW-1:0] filt_len;
  logic          uv0, ov0, uv1, ov1;

  rail_fault_sequencer #(.TW(TW), .FW(FW), .LATCH_VARIANT(1)) u0 (
    .clk(clk), .rst(rst), .hi_below(hi_below), .lo_above(lo_above),
    .pol_sel(pol_sel), .lockout(lockout), .tmo_bypass(tmo_bypass),
    .tmo_load(tmo_load), .filt_len(filt_len), .ovl_ctrl(lat_in),
    .uv_n(uv0), .ov_n(ov0));

  rail_fault_sequencer #(.TW(TW), .FW(FW), .LATCH_VARIANT(0)) u1 (
    .clk(clk), .rst(rst), .hi_below(hi_below), .lo_above(lo_above),
    .pol_sel(pol_sel), .lockout(lockout), .tmo_bypass(tmo_bypass),
    .tmo_load(tmo_load), .filt_len(filt_len), .ovl_ctrl(dis_in),
    .uv_n(uv1), .ov_n(ov1));

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit    chk_on = 0;

  task automatic chk(string t, logic a, logic e, string what);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", t, what, a, e);
    end
  endtask

  task automatic chk_int(string t, int a, int e, string what);
    n_cmp++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", t, what, a, e);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int eff_len();
    if (tmo_bypass || tmo_load == 0) return 1;
    return int'(tmo_load);
  endfunction

  function automatic bit rail_neg(int r, int p);
    if (r == 2) return p == 0;
    if (r == 3) return p < 2;
    return 1'b0;
  endfunction

  // cycle model: sample side state per variant (0 latching, 1 disable)
  int uc[2], oc[2], run[8];
  bit ol[2], mf[8];
  initial begin
    uc[0] = 0; uc[1] = 0; oc[0] = BIG; oc[1] = BIG; ol[0] = 0; ol[1] = 0;
    for (int i = 0; i < 8; i++) begin mf[i] = 0; run[i] = 0; end
  end

  always @(posedge clk) begin
    bit uf, of, rb, dv, lv;
    int need, ln;
    uf = 0; of = 0; ln = eff_len();
    for (int r = 0; r < 4; r++) begin
      if (mf[r])   begin if (rail_neg(r, int'(pol_sel))) of = 1; else uf = 1; end
      if (mf[r+4]) begin if (rail_neg(r, int'(pol_sel))) uf = 1; else of = 1; end
    end
    for (int v = 0; v < 2; v++) begin
      dv = (v == 1) && dis_in;
      lv = (v == 0);
      if (rst || lockout) uc[v] = 0;
      else if (dv) uc[v] = BIG;
      else if (uf) uc[v] = 0;
      else if (uc[v] < BIG) uc[v]++;
      if (rst || lockout) begin oc[v] = BIG; ol[v] = 0; end
      else if (dv) oc[v] = BIG;
      else if (lv && lat_in && ol[v]) begin ol[v] = 0; oc[v] = of ? 0 : BIG; end
      else if (of) begin oc[v] = 0; ol[v] = lv && !lat_in; end
      else if (oc[v] < ln && lv && !lat_in) ol[v] = 1;
      else if (oc[v] < BIG) oc[v]++;
    end
    need = (filt_len == 0) ? 1 : int'(filt_len);
    for (int i = 0; i < 8; i++) begin
      rb = (i < 4) ? hi_below[i] : lo_above[i-4];
      if (rst) begin mf[i] = 0; run[i] = 0; end
      else if (rb == mf[i]) run[i] = 0;
      else begin
        run[i]++;
        if (run[i] >= need) begin mf[i] = rb; run[i] = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      int ln;
      ln = eff_len();
      chk(tag, uv0, uc[0] >= ln, "u0 uv_n vs model");
      chk(tag, ov0, oc[0] >= ln, "u0 ov_n vs model");
      chk(tag, uv1, uc[1] >= ln, "u1 uv_n vs model");
      chk(tag, ov1, oc[1] >= ln, "u1 ov_n vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  function automatic logic pick(int sel);
    case (sel)
      0: return uv0;
      1: return ov0;
      default: return uv1;
    endcase
  endfunction

  task automatic measure(int sel, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (pick(sel) == 1'b0 && n < 40);
    #1;
  endtask

  function automatic bit sweep_fault(int p, int pat, bit want_uv);
    bit u, o;
    u = 0; o = 0;
    for (int r = 0; r < 4; r++) begin
      if (pat[r])   begin if (rail_neg(r, p)) o = 1; else u = 1; end
      if (pat[r+4]) begin if (rail_neg(r, p)) u = 1; else o = 1; end
    end
    return want_uv ? u : o;
  endfunction

  initial begin
    int m;
    bit [31:0] x;
    rst = 1; hi_below = 0; lo_above = 0; pol_sel = 2'b10; lockout = 0;
    tmo_bypass = 0; tmo_load = 3; filt_len = 1; lat_in = 1; dis_in = 0;
    tick(3);
    chk_on = 1; tag = "R1";
    tick(2);
    chk("R1", uv0, 1'b0, "u0 uv_n in reset");
    chk("R1", ov0, 1'b1, "u0 ov_n in reset");
    chk("R1", uv1, 1'b0, "u1 uv_n in reset");
    chk("R1", ov1, 1'b1, "u1 ov_n in reset");
    rst = 0;
    tick(10);

    // exhaustive flag sweep under every polarity code
    tmo_bypass = 1; filt_len = 1;
    for (int p = 0; p < 4; p++) begin
      for (int pat = 0; pat < 256; pat++) begin
        pol_sel = p[1:0];
        {lo_above, hi_below} = pat[7:0];
        tag = ((pat & 8'hCC) == 0) ? "R2" : "R3";
        tick(3);
        chk(tag, uv0, !sweep_fault(p, pat, 1'b1), "sweep uv_n");
        chk(tag, ov0, !sweep_fault(p, pat, 1'b0), "sweep ov_n");
      end
    end
    hi_below = 0; lo_above = 0; pol_sel = 2'b10;
    tick(5);

    // release hold length vs load and filter
    tag = "R5";
    for (int ld = 0; ld < 7; ld++) begin
      for (int n = 0; n < 4; n++) begin
        filt_len = n[FW-1:0];
        hi_below[0] = 1; tick();
        tmo_bypass = 0; tmo_load = ld[TW-1:0];
        tick(6);
        hi_below[0] = 0;
        measure(0, m);
        chk_int("R5", m, (n == 0 ? 1 : n) + (ld == 0 ? 1 : ld), "uv release edges");
      end
    end
    tick(10);

    // restart on a fault in the hold, negative rail 3
    tag = "R6"; filt_len = 1;
    hi_below[0] = 1; tick(); tmo_load = 6; tick(3);
    hi_below[0] = 0; tick(3);
    pol_sel = 2'b00; lo_above[2] = 1; tick();
    lo_above[2] = 0;
    measure(0, m);
    chk_int("R6", m, 7, "uv release after restart");
    pol_sel = 2'b10;
    tick(10);

    // bypass
    tag = "R7";
    hi_below[0] = 1; tick(); tmo_bypass = 1; filt_len = 2; tick(4);
    hi_below[0] = 0;
    measure(0, m);
    chk_int("R7", m, 3, "uv release with bypass");
    tick(5);

    // glitch filter
    tag = "R8";
    hi_below[0] = 1; tick(); tmo_bypass = 0; tmo_load = 2; filt_len = 3; tick(5);
    hi_below[0] = 0;
    measure(0, m);
    chk_int("R8", m, 5, "uv release with filter 3");
    tick(10);
    hi_below[0] = 1; tick(2); hi_below[0] = 0;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk("R8", uv0, 1'b1, "short pulse ignored");
    end
    hi_below[0] = 1; tick(3); hi_below[0] = 0; tick();
    chk("R8", uv0, 1'b0, "full-length pulse accepted");
    tick(15);

    // lockout
    tag = "R9"; tmo_load = 4; filt_len = 1;
    lo_above[0] = 1; tick(3);
    chk("R4", ov0, 1'b0, "ov fault asserts ov_n");
    lockout = 1; tick();
    chk("R9", uv0, 1'b0, "lockout uv_n u0");
    chk("R9", ov0, 1'b1, "lockout ov_n u0");
    chk("R9", uv1, 1'b0, "lockout uv_n u1");
    chk("R9", ov1, 1'b1, "lockout ov_n u1");
    lo_above[0] = 0; tick(2);
    lockout = 0;
    measure(0, m);
    chk_int("R9", m, 4, "uv release after lockout");
    tick(10);
    lat_in = 0; lo_above[0] = 1; tick(2); lo_above[0] = 0; tick(6);
    chk("R10", ov0, 1'b0, "ov latched before lockout");
    lockout = 1; tick(); lockout = 0; tick(8);
    chk("R9", ov0, 1'b1, "lockout cleared ov latch");
    lat_in = 1; tick(10);

    // latch hold and clear
    tag = "R10";
    lat_in = 0; lo_above[1] = 1; tick(2); lo_above[1] = 0; tick(12);
    chk("R10", ov0, 1'b0, "ov held past hold while latch low");
    lat_in = 1; tick();
    chk("R10", ov0, 1'b1, "latch input high clears ov");
    tick(5);
    lo_above[1] = 1; tick(2); lo_above[1] = 0;
    measure(1, m);
    chk_int("R10", m, 5, "ov hold with latch input high");
    tick(5);

    // latch input falling in the hold
    tag = "R11";
    lo_above[1] = 1; tick(2); lo_above[1] = 0; tick(2);
    lat_in = 0; tick(12);
    chk("R11", ov0, 1'b0, "ov latched from hold");
    lat_in = 1; tick();
    chk("R11", ov0, 1'b1, "latched ov cleared");
    tick(10);

    // disable variant
    tag = "R12";
    dis_in = 1; hi_below = 4'hF; lo_above = 4'hF; tick(4);
    chk("R12", uv1, 1'b1, "disable forces uv_n high");
    chk("R12", ov1, 1'b1, "disable forces ov_n high");
    chk("R4", uv0, 1'b0, "latch variant unaffected uv_n");
    chk("R4", ov0, 1'b0, "latch variant unaffected ov_n");
    hi_below = 0; lo_above = 0; tick(10);
    tag = "R13";
    lockout = 1; tick();
    chk("R13", uv1, 1'b0, "lockout under disable uv_n");
    chk("R13", ov1, 1'b1, "lockout under disable ov_n");
    lockout = 0; tick();
    chk("R13", uv1, 1'b1, "immediate release after lockout");
    dis_in = 0; tick(2);
    chk("R13", uv1, 1'b1, "stays released after disable drops");
    tick(10);

    // pseudo-random segments
    tag = "R4";
    x = 32'h1234_5679;
    for (int s = 0; s < 20; s++) begin
      hi_below = 0; lo_above = 0; lockout = 0; lat_in = 1; dis_in = 0;
      tick(20);
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      tmo_load   = TW'(x[2:0]);
      tmo_bypass = x[3];
      filt_len   = FW'(x[5:4]);
      for (int k = 0; k < 300; k++) begin
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        for (int i = 0; i < 4; i++) begin
          hi_below[i] = (x[4*i +: 4] == 4'd0);
          lo_above[i] = (x[16 + 4*i +: 4] == 4'd0);
        end
        pol_sel = x[9:8];
        lockout = (x[31:26] == 6'd0);
        lat_in  = (x[30:28] != 3'd0);
        dis_in  = s[0] && (x[27:25] != 3'd0);
        tick();
      end
    end
    hi_below = 0; lo_above = 0; lockout = 0; lat_in = 1; dis_in = 0;
    tick(20);
    finish_run();
  end
endmodule